// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Line Buffer

This block moves lines of RGB pixels from a video-rate write clock into an unrelated, faster processing clock. It contains two line memories. The writer fills one of them while the reader streams out the other. Ownership of each memory changes hands only once a whole line is complete. It is the single point where pixel data crosses between the two clock domains. Each side has its own reset, and the two clocks have no phase relation.

The writer presents one pixel per cycle on `wr_valid`/`wr_data`. It raises `wr_eol` with the last pixel of a line, and that pixel belongs to the line. The writer side cannot be stalled. When a line is finished, the writer toggles a per-memory handover bit that reaches the reader through a two-flop synchronizer. The line length travels with that bit. The reader returns a memory by toggling a release bit in the opposite direction.

The read side is a valid/ready stream. A beat transfers on a rising `rclk` edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the beat on the outputs is held unchanged. `rd_valid` never drops without a transfer. `rd_sol` flags the first beat of every line.

Top module: `line_pingpong_cdc`

## Requirements
- R1: After both resets, `rd_valid` and `wr_overflow` are 0, and both memories belong to the writer. As a result, two complete lines are accepted before any is read.
- R2: Pixels come out in the order they were written, with their 24-bit values unchanged. Lines come out in the order they were accepted, with nothing inserted between them.
- R3: `rd_sol` is 1 on the first beat of each line and 0 on every other beat. It is never 1 while `rd_valid` is 0.
- R4: While `rd_valid` is 1 and `rd_ready` is 0, the next cycle still has `rd_valid` at 1 with the same `rd_data` and `rd_sol`.
- R5: With the reader stalled, two complete lines are held in full. A memory returns to the writer only after its last pixel has transferred.
- R6: Some lines cannot be stored because the target memory is still owned by the reader at any pixel of that line. Such a line is discarded whole, and none of its pixels are ever emitted. In that case `wr_overflow` goes to 1 and stays at 1 until the write-side reset.
- R7: Pixels of a line beyond `LINE_MAX` (default 720) are dropped. A line longer than that is emitted as exactly `LINE_MAX` beats.
- R8: A pixel written with `wr_eol` set and no earlier pixel forms a one-pixel line. It is emitted as a single beat with `rd_sol` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Video-side clock |
| wrst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_valid | input | 1 | Pixel present this cycle |
| wr_data | input | PIX_W | Pixel in RGB, 8 bits per channel by default |
| wr_eol | input | 1 | Pixel is the last of its line |
| wr_overflow | output | 1 | Sticky: a line was discarded |
| rclk | input | 1 | Processing-side clock |
| rrst_n | input | 1 | Active-low asynchronous reset, read domain |
| rd_valid | output | 1 | Beat available |
| rd_ready | input | 1 | Consumer accepts the beat |
| rd_data | output | PIX_W | Pixel of the current beat |
| rd_sol | output | 1 | Beat is the first of a line |

## Verification
A handover toggle or release toggle left in the wrong state has two possible effects. The reader may emit a line that was never completed, which appears as a spurious beat on the first read cycle after the synchronizer delay. Or a free memory may look busy, so the next line is discarded and `wr_overflow` rises a few write clocks after that line's end. A read pointer or memory select off by one shows on the very next beat as a wrong pixel value or a misplaced `rd_sol`. The bench therefore compares every beat against a queue model and checks the overflow flag a few cycles after each line.

// File: rtl/lpp_pkg.sv
package lpp_pkg;
  // number of line memories; the handover scheme is built for exactly two
  localparam int unsigned NUM_BUFS = 2;

  typedef enum logic {
    BANK_0 = 1'b0,
    BANK_1 = 1'b1
  } bank_e;

  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction

  function automatic int unsigned count_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/lpp_sync.sv
module lpp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lpp_line_ram.sv
module lpp_line_ram #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned DEPTH = 720,
  localparam int unsigned AW   = lpp_pkg::addr_bits(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic             wbank,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             rbank,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] bank_q [lpp_pkg::NUM_BUFS];

  genvar b;
  generate
    for (b = 0; b < lpp_pkg::NUM_BUFS; b++) begin : g_bank
      logic [PIX_W-1:0] mem [DEPTH];
      always_ff @(posedge wclk) begin
        if (we && (wbank == b[0])) mem[waddr] <= wdata;
      end
      // read side only addresses a bank it owns, so contents are stable
      assign bank_q[b] = mem[raddr];
    end
  endgenerate

  assign rdata = bank_q[rbank];
endmodule

// File: rtl/lpp_wr_ctrl.sv
module lpp_wr_ctrl #(
  parameter int unsigned LINE_MAX = 720,
  localparam int unsigned AW      = lpp_pkg::addr_bits(LINE_MAX),
  localparam int unsigned LW      = lpp_pkg::count_bits(LINE_MAX),
  localparam int unsigned NB      = lpp_pkg::NUM_BUFS
) (
  input  logic                 wclk,
  input  logic                 wrst_n,
  input  logic                 in_valid,
  input  logic                 in_eol,
  input  logic [NB-1:0]        rel_sync,   // reader release toggles, synchronized
  output logic                 we,
  output logic                 wbank,
  output logic [AW-1:0]        waddr,
  output logic [NB-1:0]        hand_tog,   // writer handover toggles
  output logic [NB-1:0][LW-1:0] line_len,
  output logic                 overflow
);
  logic          sel;
  logic [LW-1:0] cnt;
  logic          dropped;
  logic          free;
  logic          room;

  assign free  = (hand_tog[sel] == rel_sync[sel]);
  assign room  = (cnt < LW'(LINE_MAX));
  assign we    = in_valid && free && !dropped && room;
  assign wbank = sel;
  assign waddr = AW'(cnt);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      sel      <= lpp_pkg::BANK_0;
      cnt      <= '0;
      dropped  <= 1'b0;
      hand_tog <= '0;
      line_len <= '0;
      overflow <= 1'b0;
    end else if (in_valid) begin
      if (in_eol) begin
        if (free && !dropped) begin
          line_len[sel] <= room ? cnt + LW'(1) : cnt;
          hand_tog[sel] <= ~hand_tog[sel];
          sel           <= ~sel;
        end else begin
          overflow <= 1'b1;
        end
        cnt     <= '0;
        dropped <= 1'b0;
      end else begin
        if (!free) dropped <= 1'b1;
        if (room)  cnt     <= cnt + LW'(1);
      end
    end
  end
endmodule

// File: rtl/lpp_rd_ctrl.sv
module lpp_rd_ctrl #(
  parameter int unsigned LINE_MAX = 720,
  localparam int unsigned AW      = lpp_pkg::addr_bits(LINE_MAX),
  localparam int unsigned LW      = lpp_pkg::count_bits(LINE_MAX),
  localparam int unsigned NB      = lpp_pkg::NUM_BUFS
) (
  input  logic                  rclk,
  input  logic                  rrst_n,
  input  logic [NB-1:0]         hand_sync,  // writer handover toggles, synchronized
  input  logic [NB-1:0][LW-1:0] line_len,   // stable while the bank is reader-owned
  input  logic                  ready,
  output logic                  valid,
  output logic                  sol,
  output logic                  rbank,
  output logic [AW-1:0]         raddr,
  output logic [NB-1:0]         rel_tog
);
  logic          sel;
  logic [LW-1:0] ptr;
  logic          last;

  assign valid = (hand_sync[sel] != rel_tog[sel]);
  assign sol   = valid && (ptr == '0);
  assign rbank = sel;
  assign raddr = AW'(ptr);
  assign last  = (ptr + LW'(1) >= line_len[sel]);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      sel     <= lpp_pkg::BANK_0;
      ptr     <= '0;
      rel_tog <= '0;
    end else if (valid && ready) begin
      if (last) begin
        ptr          <= '0;
        rel_tog[sel] <= ~rel_tog[sel];
        sel          <= ~sel;
      end else begin
        ptr <= ptr + LW'(1);
      end
    end
  end
endmodule

// File: rtl/line_pingpong_cdc.sv
module line_pingpong_cdc #(
  parameter int unsigned PIX_W       = 24,
  parameter int unsigned LINE_MAX    = 720,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_valid,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             wr_eol,
  output logic             wr_overflow,
  input  logic             rclk,
  input  logic             rrst_n,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [PIX_W-1:0] rd_data,
  output logic             rd_sol
);
  localparam int unsigned AW = lpp_pkg::addr_bits(LINE_MAX);
  localparam int unsigned LW = lpp_pkg::count_bits(LINE_MAX);
  localparam int unsigned NB = lpp_pkg::NUM_BUFS;

  logic                  ram_we;
  logic                  ram_wbank;
  logic [AW-1:0]         ram_waddr;
  logic                  ram_rbank;
  logic [AW-1:0]         ram_raddr;
  logic [NB-1:0]         wr_hand;
  logic [NB-1:0]         wr_hand_s;
  logic [NB-1:0]         rd_rel;
  logic [NB-1:0]         rd_rel_s;
  logic [NB-1:0][LW-1:0] len_q;

  lpp_wr_ctrl #(.LINE_MAX(LINE_MAX)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n),
    .in_valid(wr_valid), .in_eol(wr_eol),
    .rel_sync(rd_rel_s),
    .we(ram_we), .wbank(ram_wbank), .waddr(ram_waddr),
    .hand_tog(wr_hand), .line_len(len_q),
    .overflow(wr_overflow)
  );

  lpp_sync #(.WIDTH(NB), .STAGES(SYNC_STAGES)) u_sync_hand (
    .clk(rclk), .rst_n(rrst_n), .d(wr_hand), .q(wr_hand_s)
  );

  lpp_sync #(.WIDTH(NB), .STAGES(SYNC_STAGES)) u_sync_rel (
    .clk(wclk), .rst_n(wrst_n), .d(rd_rel), .q(rd_rel_s)
  );

  lpp_line_ram #(.PIX_W(PIX_W), .DEPTH(LINE_MAX)) u_ram (
    .wclk(wclk), .we(ram_we), .wbank(ram_wbank), .waddr(ram_waddr),
    .wdata(wr_data), .rbank(ram_rbank), .raddr(ram_raddr), .rdata(rd_data)
  );

  lpp_rd_ctrl #(.LINE_MAX(LINE_MAX)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n),
    .hand_sync(wr_hand_s), .line_len(len_q),
    .ready(rd_ready),
    .valid(rd_valid), .sol(rd_sol),
    .rbank(ram_rbank), .raddr(ram_raddr),
    .rel_tog(rd_rel)
  );
endmodule

// File: rtl/line_pingpong_cdc_chk.sv
module line_pingpong_cdc_chk #(
  parameter int unsigned PIX_W    = 24,
  parameter int unsigned LINE_MAX = 720
) (
  input logic             wclk,
  input logic             wrst_n,
  input logic             wr_overflow,
  input logic             rclk,
  input logic             rrst_n,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [PIX_W-1:0] rd_data,
  input logic             rd_sol,
  input logic [1:0]       rd_rel
);
  logic [31:0] beats;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)                   beats <= '0;
    else if (rd_valid && rd_ready) beats <= rd_sol ? 32'd1 : beats + 32'd1;
  end

  p_hold_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_sol)));

  p_sol_valid_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_sol |-> rd_valid);

  p_release_after_beat_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    !$stable(rd_rel) |-> $past(rd_valid && rd_ready));

  p_line_cap_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    beats <= LINE_MAX);

  p_no_overflow_clear_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_overflow |=> wr_overflow);
endmodule

bind line_pingpong_cdc line_pingpong_cdc_chk #(.PIX_W(PIX_W), .LINE_MAX(LINE_MAX)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wr_overflow(wr_overflow),
  .rclk(rclk), .rrst_n(rrst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_sol(rd_sol), .rd_rel(rd_rel)
);

// File: tb/line_pingpong_cdc_test.sv
module line_pingpong_cdc_test;
  localparam int CLK_PERIOD  = 10;
  localparam int WCLK_PERIOD = 37;
  localparam int PIX_W       = 24;
  localparam int LINE_MAX    = 720;

  logic             wclk = 0, rclk = 0;
  logic             wrst_n = 0, rrst_n = 0;
  logic             wr_valid = 0, wr_eol = 0;
  logic [PIX_W-1:0] wr_data = '0;
  logic             wr_overflow;
  logic             rd_valid, rd_sol;
  logic             rd_ready = 0;
  logic [PIX_W-1:0] rd_data;

  always #(CLK_PERIOD/2) rclk = ~rclk;
  always #(WCLK_PERIOD/2.0) wclk = ~wclk;

  line_pingpong_cdc uut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_eol(wr_eol), .wr_overflow(wr_overflow),
    .rclk(rclk), .rrst_n(rrst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_sol(rd_sol)
  );

  int checks = 0, errors = 0;
  int inflight = 0;
  int rdy_mode = 0;        // 0 stall, 1 always ready, 2 random
  bit ovf_exp = 0;
  string cur_req = "R2";
  logic [25:0] expq[$];    // {last, sol, pixel}
  bit prev_stall = 0;
  logic [PIX_W-1:0] prev_data;
  logic prev_sol;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] pix(input int tag, input int i);
    return {tag[7:0], i[15:0]};
  endfunction

  // read-side reference model, compared every rclk
  always @(negedge rclk) begin
    case (rdy_mode)
      0: rd_ready = 1'b0;
      1: rd_ready = 1'b1;
      default: rd_ready = $urandom_range(0, 1);
    endcase
    #1;
    if (rrst_n) begin
      if (prev_stall)
        chk(rd_valid && rd_data == prev_data && rd_sol == prev_sol, "R4",
            {rd_valid, rd_data}, {1'b1, prev_data});
      if (rd_sol) chk(rd_valid, "R3", rd_valid, 1);
      if (rd_valid) begin
        if (expq.size() == 0) begin
          chk(0, "R2 spurious beat", rd_data, 0);
        end else if (rd_ready) begin
          logic [25:0] it;
          it = expq.pop_front();
          chk(rd_data == it[23:0], cur_req, rd_data, it[23:0]);
          chk(rd_sol == it[24], "R3", rd_sol, it[24]);
          if (it[25]) inflight--;
        end
      end
      prev_stall = rd_valid && !rd_ready;
      prev_data  = rd_data;
      prev_sol   = rd_sol;
    end else begin
      prev_stall = 0;
    end
  end

  task automatic send_line(input int n, input int tag);
    bit acc;
    int keep;
    acc  = (inflight < 2);
    keep = (n > LINE_MAX) ? LINE_MAX : n;
    if (acc) begin
      inflight++;
      for (int k = 0; k < keep; k++)
        expq.push_back({k == keep - 1, k == 0, pix(tag, k)});
    end else begin
      ovf_exp = 1;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_valid = 1;
      wr_data  = pix(tag, i);
      wr_eol   = (i == n - 1);
    end
    @(negedge wclk);
    wr_valid = 0;
    wr_eol   = 0;
    repeat (3) @(negedge wclk);
    chk(wr_overflow == ovf_exp, acc ? "R5" : "R6", wr_overflow, ovf_exp);
  endtask

  task automatic drain;
    wait (inflight == 0);
    repeat (10) @(negedge wclk);
    chk(!rd_valid && expq.size() == 0, "R2", rd_valid, 0);
  endtask

  task automatic do_reset;
    @(negedge wclk);
    wrst_n = 0;
    rrst_n = 0;
    repeat (4) @(negedge wclk);
    chk(rd_valid == 0, "R1", rd_valid, 0);
    chk(wr_overflow == 0, "R1", wr_overflow, 0);
    wrst_n = 1;
    rrst_n = 1;
    ovf_exp = 0;
    repeat (4) @(negedge wclk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R2, R3: simple line, always ready
    rdy_mode = 1; cur_req = "R2";
    send_line(5, 1);
    drain();

    // R4: random back-pressure
    rdy_mode = 2;
    send_line(40, 2);
    drain();

    // R5, R6: reader stalled, two lines held, then discards
    rdy_mode = 0;
    send_line(6, 3);
    send_line(7, 4);
    repeat (5) @(negedge wclk);
    chk(rd_valid && rd_sol && rd_data == pix(3, 0), "R5", rd_data, pix(3, 0));
    send_line(5, 5);
    send_line(4, 6);
    rdy_mode = 1;
    drain();
    chk(wr_overflow == 1, "R6 sticky", wr_overflow, 1);
    send_line(3, 7);
    drain();

    // R7: overlong line truncated
    cur_req = "R7";
    send_line(LINE_MAX + 5, 8);
    drain();

    // R8: single-pixel line
    cur_req = "R8";
    send_line(1, 9);
    drain();

    // R1: reset clears overflow, both banks free again
    cur_req = "R1";
    do_reset();
    rdy_mode = 0;
    send_line(2, 10);
    send_line(2, 11);
    rdy_mode = 1;
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule